// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether a guest I/O access must be handed back to the hypervisor. A permission bitmap in memory has one bit per port; a set bit means that port is intercepted. For each request the block reads two consecutive bitmap bytes through a one-byte read port, one after the other. It joins them into a 16-bit window and tests every port the access covers against that window. An access of two or four bytes can therefore cross a byte boundary of the bitmap and still be checked in full.

When an access is intercepted, the block builds the exit qualification word from the already-decoded instruction flags, the access size and the port number. It reports that word together with the instruction pointer. If the guest is not running, or I/O interception is switched off as a whole, the request completes at once. No memory read takes place and no exit is requested.

Top module: `io_perm_check`

## Requirements
- R1: After reset, busy, done, exit_req and mem_req are all low.
- R2: A request taken while guest_active is low or io_icpt_en is low causes no memory read. done pulses in the cycle after the request with exit_req low and both exit-info outputs zero.
- R3: Otherwise the block makes exactly two one-byte reads, one at a time. The first is at (bitmap_base with its low 12 bits cleared) + port/8 and the second is at that address + 1. mem_addr is held while mem_req waits for mem_ready.
- R4: The block forms a 16-bit value with the second byte as bits 15:8 and the first byte as bits 7:0. It tests that value against ((1<<len)-1) << (port mod 8), where len is 1, 2 or 4. Any common set bit requests an exit.
- R5: Qualification: bit 0 = input direction, bit 2 = string, bit 3 = repeat (set only when string is also set), bits 4/5/6 = 1/2/4-byte size, bits 31:16 = port. All other bits are zero.
- R6: On an exit, exit_info1 carries the qualification and exit_info2 carries the instruction pointer captured with the request. Without an exit, exit_req is low and both outputs are zero.
- R7: busy is high from acceptance of a checked request until its done. A request strobe seen while busy is ignored.
- R8: exit_req is only ever high in a cycle where done is high, and done is one cycle wide per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_port | input | 16 | I/O port number |
| req_len | input | 3 | Access size in bytes: 1, 2 or 4 |
| req_in | input | 1 | 1 = input, 0 = output |
| req_str | input | 1 | String instruction |
| req_rep | input | 1 | Repeat prefix present |
| req_ip | input | 64 | Instruction pointer of the access |
| bitmap_base | input | ADDR_W | Bitmap base; low 12 bits ignored |
| guest_active | input | 1 | Guest mode active |
| io_icpt_en | input | 1 | Global I/O intercept enable |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | ADDR_W | Byte read address |
| mem_ready | input | 1 | Read request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle completion pulse |
| exit_req | output | 1 | Exit requested, valid with done |
| exit_info1 | output | 64 | Qualification word |
| exit_info2 | output | 64 | Instruction pointer on exit |

## Verification
The assertions assume that req_len is always 1, 2 or 4 and that the memory side returns exactly one data beat for each accepted read, never before that read is accepted. The bench drives only these three lengths. Its memory model logs each accepted address and answers it once, one cycle later. It can also hold mem_ready low on alternate cycles to exercise the held-address case.

// File: rtl/io_perm_pkg.sv
package io_perm_pkg;

    localparam int PORT_W = 16;
    localparam int INFO_W = 64;

    typedef enum logic [2:0] {
        FS_IDLE  = 3'd0,
        FS_ASK0  = 3'd1,
        FS_WAIT0 = 3'd2,
        FS_ASK1  = 3'd3,
        FS_WAIT1 = 3'd4
    } fetch_state_e;

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic [2:0]        len;
        logic              inbound;
        logic              strng;
        logic              repeat_pf;
        logic [INFO_W-1:0] ip;
    } io_access_t;

    // Bits of the 16-bit bitmap window touched by an access.
    function automatic logic [15:0] span_mask(input logic [PORT_W-1:0] port,
                                              input logic [2:0] len);
        logic [15:0] ones;
        ones = (16'd1 << len) - 16'd1;
        return ones << port[2:0];
    endfunction

    // Exit qualification word for an intercepted access.
    function automatic logic [INFO_W-1:0] pack_qual(input io_access_t a);
        logic [INFO_W-1:0] q;
        q        = '0;
        q[0]     = a.inbound;
        q[2]     = a.strng;
        q[3]     = a.strng & a.repeat_pf;
        q[4]     = (a.len == 3'd1);
        q[5]     = (a.len == 3'd2);
        q[6]     = (a.len == 3'd4);
        q[31:16] = a.port;
        return q;
    endfunction

endpackage

// File: rtl/io_perm_fetch.sv
module io_perm_fetch
    import io_perm_pkg::*;
#(
    parameter int ADDR_W = 52
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] first_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    output logic              word_valid,
    output logic [15:0]       word
);

    fetch_state_e      state;
    logic [ADDR_W-1:0] addr_r;
    logic [7:0]        lo_r;
    logic [15:0]       word_r;
    logic              wv_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= FS_IDLE;
            addr_r <= '0;
            lo_r   <= '0;
            word_r <= '0;
            wv_r   <= 1'b0;
        end else begin
            wv_r <= 1'b0;
            case (state)
                FS_IDLE: if (start) begin
                    addr_r <= first_addr;
                    state  <= FS_ASK0;
                end
                FS_ASK0: if (mem_ready) state <= FS_WAIT0;
                FS_WAIT0: if (mem_rvalid) begin
                    lo_r   <= mem_rdata;
                    addr_r <= addr_r + ADDR_W'(1);
                    state  <= FS_ASK1;
                end
                FS_ASK1: if (mem_ready) state <= FS_WAIT1;
                FS_WAIT1: if (mem_rvalid) begin
                    word_r <= {mem_rdata, lo_r};
                    wv_r   <= 1'b1;
                    state  <= FS_IDLE;
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    assign mem_req    = (state == FS_ASK0) || (state == FS_ASK1);
    assign mem_addr   = addr_r;
    assign word_valid = wv_r;
    assign word       = word_r;

    // R3: a waiting read keeps its address until accepted
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    // R3: the joined word only appears after a data beat
    p_word_after_beat_r3: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(mem_rvalid));

endmodule

// File: rtl/io_perm_decide.sv
module io_perm_decide
    import io_perm_pkg::*;
(
    input  io_access_t        acc,
    input  logic [15:0]       window,
    output logic              hit,
    output logic [INFO_W-1:0] qual
);

    logic [15:0] mask;

    always_comb begin
        mask = span_mask(acc.port, acc.len);
        hit  = |(window & mask);
        qual = pack_qual(acc);
    end

endmodule

// File: rtl/io_perm_check.sv
module io_perm_check
    import io_perm_pkg::*;
#(
    parameter int ADDR_W    = 52,
    parameter int PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [15:0]       req_port,
    input  logic [2:0]        req_len,
    input  logic              req_in,
    input  logic              req_str,
    input  logic              req_rep,
    input  logic [63:0]       req_ip,
    input  logic [ADDR_W-1:0] bitmap_base,
    input  logic              guest_active,
    input  logic              io_icpt_en,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              exit_req,
    output logic [63:0]       exit_info1,
    output logic [63:0]       exit_info2
);

    localparam int BYTE_IDX_W = PORT_W - 3;

    logic              busy_r, done_r, exit_r;
    logic [63:0]       info1_r, info2_r;
    io_access_t        acc_r;
    logic              accept, gate_on, start_fetch;
    logic [ADDR_W-1:0] first_addr;
    logic              word_valid, hit;
    logic [15:0]       window;
    logic [INFO_W-1:0] qual;

    assign accept      = req_valid && !busy_r;
    assign gate_on     = guest_active && io_icpt_en;
    assign start_fetch = accept && gate_on;
    assign first_addr  = {bitmap_base[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}}
                       + ADDR_W'(req_port[PORT_W-1:PORT_W-BYTE_IDX_W]);

    io_perm_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .start      (start_fetch),
        .first_addr (first_addr),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ready  (mem_ready),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .word_valid (word_valid),
        .word       (window)
    );

    io_perm_decide u_decide (
        .acc    (acc_r),
        .window (window),
        .hit    (hit),
        .qual   (qual)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_r  <= 1'b0;
            done_r  <= 1'b0;
            exit_r  <= 1'b0;
            info1_r <= '0;
            info2_r <= '0;
            acc_r   <= '0;
        end else begin
            done_r <= 1'b0;
            exit_r <= 1'b0;
            if (accept) begin
                acc_r <= '{port: req_port, len: req_len, inbound: req_in,
                           strng: req_str, repeat_pf: req_rep, ip: req_ip};
                if (gate_on) begin
                    busy_r <= 1'b1;
                end else begin
                    done_r  <= 1'b1;
                    info1_r <= '0;
                    info2_r <= '0;
                end
            end
            if (word_valid) begin
                busy_r  <= 1'b0;
                done_r  <= 1'b1;
                exit_r  <= hit;
                info1_r <= hit ? qual : '0;
                info2_r <= hit ? acc_r.ip : '0;
            end
        end
    end

    assign busy       = busy_r;
    assign done       = done_r;
    assign exit_req   = exit_r;
    assign exit_info1 = info1_r;
    assign exit_info2 = info2_r;

    // R2: bypassed request finishes next cycle without exit
    p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !(guest_active && io_icpt_en)) |=> (done && !exit_req));

    // R7: memory is only touched while a check is in progress
    p_mem_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R8: exit flag only together with completion
    p_exit_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        exit_req |-> done);

    // R8: a checked request completes with exactly one done pulse
    p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy)) |-> done);

    // R5: size field is one-hot and repeat implies string
    p_qual_shape_r5: assert property (@(posedge clk) disable iff (rst)
        exit_req |-> ($countones(exit_info1[6:4]) == 1 && !exit_info1[1]
                      && !(exit_info1[3] && !exit_info1[2])));

endmodule

// File: tb/io_perm_check_bench.sv
module io_perm_check_bench;

    localparam int AW = 52;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [15:0]   req_port = '0;
    logic [2:0]    req_len = 3'd1;
    logic          req_in = 1'b0, req_str = 1'b0, req_rep = 1'b0;
    logic [63:0]   req_ip = '0;
    logic [AW-1:0] bitmap_base = '0;
    logic          guest_active = 1'b0, io_icpt_en = 1'b0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_ready = 1'b1;
    logic          mem_rvalid = 1'b0;
    logic [7:0]    mem_rdata = '0;
    logic          busy, done, exit_req;
    logic [63:0]   exit_info1, exit_info2;

    always #10 clk = ~clk;

    io_perm_check #(.ADDR_W(AW)) u_io_perm_check (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_port(req_port),
        .req_len(req_len), .req_in(req_in), .req_str(req_str), .req_rep(req_rep),
        .req_ip(req_ip), .bitmap_base(bitmap_base), .guest_active(guest_active),
        .io_icpt_en(io_icpt_en), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .exit_req(exit_req),
        .exit_info1(exit_info1), .exit_info2(exit_info2)
    );

    int n_chk = 0, n_bad = 0;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Memory model
    logic [7:0]    cur_b0 = '0, cur_b1 = '0;
    logic [AW-1:0] exp_a0 = '0;
    logic [AW-1:0] log_a0 = '0, log_a1 = '0;
    int            n_reads = 0;
    bit            stall_mode = 0;
    bit            pend = 0;
    logic [AW-1:0] paddr = '0;

    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (pend) begin
                mem_rvalid = 1'b1;
                mem_rdata  = (paddr == exp_a0) ? cur_b0 :
                             (paddr == exp_a0 + 1) ? cur_b1 : 8'hEE;
                pend = 0;
            end
            mem_ready = stall_mode ? ~mem_ready : 1'b1;
            if (mem_req && mem_ready) begin
                pend  = 1;
                paddr = mem_addr;
                if (n_reads == 0) log_a0 = mem_addr;
                if (n_reads == 1) log_a1 = mem_addr;
                n_reads++;
            end
        end
    end

    // Stimulus table: port, len, in, str, rep, byte0, byte1
    typedef struct packed {
        logic [15:0] port;
        logic [2:0]  len;
        logic        din;
        logic        str;
        logic        rep;
        logic [7:0]  b0;
        logic [7:0]  b1;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VT [NV] = '{
        '{16'h0060, 3'd1, 1'b1, 1'b0, 1'b0, 8'h01, 8'h00},
        '{16'h0061, 3'd1, 1'b0, 1'b0, 1'b0, 8'h01, 8'h00},
        '{16'h03FE, 3'd2, 1'b1, 1'b0, 1'b0, 8'h00, 8'h01},
        '{16'h03FF, 3'd2, 1'b0, 1'b1, 1'b1, 8'h00, 8'h01},
        '{16'h1234, 3'd4, 1'b1, 1'b1, 1'b0, 8'h80, 8'h00},
        '{16'hFFFF, 3'd4, 1'b0, 1'b0, 1'b1, 8'h00, 8'h04},
        '{16'h8005, 3'd4, 1'b1, 1'b1, 1'b1, 8'h1F, 8'hF0},
        '{16'h0CF8, 3'd4, 1'b0, 1'b0, 1'b0, 8'h0F, 8'h00}
    };

    function automatic logic [63:0] ref_qual(input logic [15:0] p, input logic [2:0] l,
                                             input logic di, input logic s, input logic r);
        logic [63:0] q;
        q = '0;
        q[0] = di; q[2] = s; q[3] = s & r;
        q[4] = (l == 1); q[5] = (l == 2); q[6] = (l == 4);
        q[31:16] = p;
        return q;
    endfunction

    function automatic bit ref_hit(input logic [15:0] p, input logic [2:0] l,
                                   input logic [7:0] b0, input logic [7:0] b1);
        int m;
        m = ((1 << l) - 1) << (p % 8);
        return (({b1, b0} & m[15:0]) != 0);
    endfunction

    logic        got_exit;
    logic [63:0] got_i1, got_i2;
    int          got_cyc;

    task automatic run_req(input logic [15:0] p, input logic [2:0] l, input logic di,
                           input logic s, input logic r, input logic [63:0] ip);
        n_reads = 0;
        got_cyc = 0;
        @(negedge clk);
        req_valid = 1; req_port = p; req_len = l; req_in = di;
        req_str = s; req_rep = r; req_ip = ip;
        @(negedge clk);
        req_valid = 0;
        got_cyc = 1;
        while (!done && got_cyc < 60) begin
            @(negedge clk);
            got_cyc++;
        end
        got_exit = exit_req; got_i1 = exit_info1; got_i2 = exit_info2;
        if (!done) chk("R8 done never seen", 0, 1);
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] eq;
        bit          eh;
        repeat (3) @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 done after reset", done, 0);
        chk("R1 exit_req after reset", exit_req, 0);
        chk("R1 mem_req after reset", mem_req, 0);
        rst = 0;
        bitmap_base = 52'h0_0012_3456_7000;
        guest_active = 1; io_icpt_en = 1;

        // Table walk: R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            cur_b0 = VT[i].b0; cur_b1 = VT[i].b1;
            exp_a0 = 52'h0_0012_3456_7000 + 52'(VT[i].port >> 3);
            run_req(VT[i].port, VT[i].len, VT[i].din, VT[i].str, VT[i].rep,
                    64'hFFFF_8000_0000_1000 + 64'(i * 16));
            eh = ref_hit(VT[i].port, VT[i].len, VT[i].b0, VT[i].b1);
            eq = ref_qual(VT[i].port, VT[i].len, VT[i].din, VT[i].str, VT[i].rep);
            chk($sformatf("R3 read count v%0d", i), 64'(n_reads), 2);
            chk($sformatf("R3 first addr v%0d", i), 64'(log_a0), 64'(exp_a0));
            chk($sformatf("R3 second addr v%0d", i), 64'(log_a1), 64'(exp_a0 + 1));
            chk($sformatf("R4 exit v%0d", i), 64'(got_exit), 64'(eh));
            chk($sformatf("R5 qual v%0d", i), got_i1, eh ? eq : 64'd0);
            chk($sformatf("R6 ip v%0d", i), got_i2,
                eh ? 64'hFFFF_8000_0000_1000 + 64'(i * 16) : 64'd0);
        end

        // R2: guest inactive
        guest_active = 0;
        run_req(16'h0060, 3'd1, 1, 0, 0, 64'h1234);
        chk("R2 inactive next-cycle done", 64'(got_cyc), 1);
        chk("R2 inactive no exit", 64'(got_exit), 0);
        chk("R2 inactive no reads", 64'(n_reads), 0);
        chk("R2 inactive info1 zero", got_i1, 0);
        guest_active = 1;

        // R2: intercept disabled
        io_icpt_en = 0;
        run_req(16'h0060, 3'd1, 1, 0, 0, 64'h5678);
        chk("R2 disabled no exit", 64'(got_exit), 0);
        chk("R2 disabled no reads", 64'(n_reads), 0);
        chk("R2 disabled info2 zero", got_i2, 0);
        io_icpt_en = 1;

        // R3: low base bits ignored, ready stalls
        bitmap_base = 52'h0_0000_0004_0ABC;
        stall_mode = 1;
        cur_b0 = 8'h00; cur_b1 = 8'h02;
        exp_a0 = 52'h0_0000_0004_0000 + 52'(16'h0117 >> 3);
        run_req(16'h0117, 3'd4, 1, 1, 1, 64'hAB);
        chk("R3 stalled first addr", 64'(log_a0), 64'(exp_a0));
        chk("R3 stalled second addr", 64'(log_a1), 64'(exp_a0 + 1));
        chk("R4 stalled cross-byte exit", 64'(got_exit), 1);
        chk("R5 stalled qual", got_i1, ref_qual(16'h0117, 3'd4, 1, 1, 1));
        stall_mode = 0;

        // R7: request while busy ignored
        cur_b0 = 8'h04; cur_b1 = 8'h00;
        exp_a0 = 52'h0_0000_0004_0000;
        n_reads = 0;
        @(negedge clk);
        req_valid = 1; req_port = 16'h0002; req_len = 3'd1; req_in = 0;
        req_str = 0; req_rep = 0; req_ip = 64'h77;
        @(negedge clk);
        chk("R7 busy after accept", busy, 1);
        req_port = 16'h0400; req_in = 1; req_ip = 64'h99;
        @(negedge clk);
        req_valid = 0;
        got_cyc = 0;
        while (!done && got_cyc < 60) begin
            @(negedge clk);
            got_cyc++;
        end
        chk("R7 first request result", exit_info1, ref_qual(16'h0002, 3'd1, 0, 0, 0));
        chk("R7 first request ip", exit_info2, 64'h77);
        @(negedge clk);
        chk("R8 done single cycle", done, 0);
        chk("R7 busy cleared", busy, 0);
        repeat (6) @(negedge clk);
        chk("R7 busy-time strobe dropped", 64'(n_reads), 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule